// File: doc/BRIEF.md
# Tagged Cache-Line Memory Responder

This block is an on-chip memory target that moves whole cache lines. A requester presents a command holding a line address, a direction flag and a tag. A write command is followed by one data beat for each word of the line, on a separate write-data channel. A read command makes the block queue one tagged response beat for each word of the line. The requester drains these beats through a response channel that honours back pressure.

Storage is a single-port word array. A small store sequencer owns the array while write beats arrive. A read sequencer owns it while it copies a line into the response queue. The command channel admits new work only when both sequencers are idle and the queue has room for a whole line. As a result, no beat is ever dropped, whatever the response consumer does.

Top module: `line_mem_responder`

## Requirements
- R1: After reset, the command ready output is 1, the write-data ready output is 0 and the response valid output is 0.
- R2: The write-data ready output is 1 exactly while a store is in progress, and the command ready output is 0 during that time. A command handshake and a write-data handshake never occur in the same cycle. Write-data valid asserted while no store is in progress writes nothing.
- R3: A command with the write flag at 1 starts a store at word index line*BEATS (BEATS = line bytes * 8 / word width, 8 by default). Each write-data handshake writes the next word in ascending order. The store ends on the BEATS-th beat, after which write-data ready is 0 and command ready is 1 again.
- R4: A command with the write flag at 0 returns BEATS response beats. The beats come in ascending word order, each carries that command's tag, and each holds the word last stored at that position.
- R5: The line address is taken modulo the memory depth in lines (32 by default), so line L and line L+32 name the same storage.
- R6: A response beat leaves only in a cycle where response valid and response ready are both 1. While valid is 1 and ready is 0, valid stays 1 and the tag and data hold steady.
- R7: The response queue holds two full lines. Command ready is 0 while fewer than BEATS entries are free, and every queued beat is delivered later.
- R8: Response valid is 1 exactly while the queue holds at least one beat. It returns to 0 once the last beat has been drained.
- R9: Reset clears the sequencers and the queue, but the stored memory contents survive it.
- R10: Command ready is 0 while an accepted read is still copying its line into the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command valid |
| cmd_ready_o | output | 1 | Command ready |
| cmd_write_i | input | 1 | 1 = write line, 0 = read line |
| cmd_line_i | input | LADDR_W (26) | Line address |
| cmd_tag_i | input | TAG_W (4) | Request tag |
| wr_valid_i | input | 1 | Write-data beat valid |
| wr_ready_o | output | 1 | Write-data beat ready |
| wr_data_i | input | WORD_W (64) | Write-data word |
| rsp_valid_o | output | 1 | Response beat valid |
| rsp_ready_i | input | 1 | Response beat ready |
| rsp_tag_o | output | TAG_W (4) | Tag of the response beat |
| rsp_data_o | output | WORD_W (64) | Data of the response beat |

## Verification
Two functions can fall in the same cycle: a read sequencer pushing a beat into the response queue, and the consumer popping a beat out of it. When both happen, the queue occupancy must stay unchanged and no beat may be skipped or repeated. The bench provokes this by holding response ready high through back-to-back reads. It also fills the queue to two lines with ready low and then releases ready while a third read is waiting. It judges the result by comparing every received tag and word, in order, against a bench-side shadow memory, and by checking that no beat moves while ready is low.

// File: rtl/lmr_pkg.sv
package lmr_pkg;
  typedef enum logic {
    CMD_READ  = 1'b0,
    CMD_WRITE = 1'b1
  } cmd_kind_e;
endpackage

// File: rtl/lmr_word_ram.sv
module lmr_word_ram #(
  parameter int WORD_W  = 64,
  parameter int WORDS   = 256,
  localparam int ADDR_W = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  // read is combinational so a beat is fetched in the cycle it is queued
  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/lmr_line_seq.sv
// Walks the words of one line; used for both store and read bursts.
module lmr_line_seq #(
  parameter int BEATS   = 8,
  parameter int LINE_W  = 5,
  parameter int TAG_W   = 4,
  parameter bit SELF_STEP = 1'b0,
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [LINE_W-1:0]        line_i,
  input  logic [TAG_W-1:0]         tag_i,
  input  logic                     step_i,
  output logic                     busy_o,
  output logic                     adv_o,
  output logic [LINE_W+BEAT_W-1:0] addr_o,
  output logic [TAG_W-1:0]         tag_o
);
  logic              busy_q;
  logic [BEAT_W-1:0] cnt_q;
  logic [LINE_W-1:0] line_q;
  logic [TAG_W-1:0]  tag_q;

  // the read variant advances every busy cycle, the store variant per beat
  generate
    if (SELF_STEP) begin : g_self
      assign adv_o = busy_q;
    end else begin : g_ext
      assign adv_o = busy_q & step_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      line_q <= '0;
      tag_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      line_q <= line_i;
      tag_q  <= tag_i;
    end else if (adv_o) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == BEAT_W'(BEATS - 1)) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign addr_o = {line_q, cnt_q};
  assign tag_o  = tag_q;

  // R3
  last_beat_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_o && !start_i && cnt_q == BEAT_W'(BEATS - 1)) |=> !busy_o);
endmodule

// File: rtl/lmr_resp_fifo.sv
module lmr_resp_fifo #(
  parameter int W       = 68,
  parameter int DEPTH   = 16,
  parameter int NEED    = 8,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic         valid_o,
  output logic [W-1:0] rdata_o,
  output logic         room_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= nxt(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  assign valid_o = (cnt_q != '0);
  assign rdata_o = mem_q[rd_ptr_q];
  assign room_o  = (CNT_W'(DEPTH) - cnt_q) >= CNT_W'(NEED);

  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |-> (cnt_q != CNT_W'(DEPTH)));
endmodule

// File: rtl/line_mem_responder.sv
module line_mem_responder
  import lmr_pkg::*;
#(
  parameter int WORD_W     = 64,
  parameter int LINE_BYTES = 64,
  parameter int MEM_LINES  = 32,
  parameter int TAG_W      = 4,
  parameter int LADDR_W    = 26,
  parameter int RESP_LINES = 2,
  localparam int BEATS     = LINE_BYTES * 8 / WORD_W,
  localparam int BEAT_W    = $clog2(BEATS),
  localparam int LINE_W    = $clog2(MEM_LINES),
  localparam int WORDS     = MEM_LINES * BEATS,
  localparam int WADDR_W   = LINE_W + BEAT_W,
  localparam int Q_DEPTH   = RESP_LINES * BEATS,
  localparam int Q_W       = TAG_W + WORD_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  output logic               cmd_ready_o,
  input  logic               cmd_write_i,
  input  logic [LADDR_W-1:0] cmd_line_i,
  input  logic [TAG_W-1:0]   cmd_tag_i,
  input  logic               wr_valid_i,
  output logic               wr_ready_o,
  input  logic [WORD_W-1:0]  wr_data_i,
  output logic               rsp_valid_o,
  input  logic               rsp_ready_i,
  output logic [TAG_W-1:0]   rsp_tag_o,
  output logic [WORD_W-1:0]  rsp_data_o
);
  logic               cmd_fire, wr_fire, rsp_fire;
  logic               st_start, rd_start;
  logic               st_busy, rd_busy, rd_push, st_adv;
  logic [WADDR_W-1:0] st_addr, rd_addr, ram_addr;
  logic [TAG_W-1:0]   rd_tag, st_tag_unused;
  logic [LINE_W-1:0]  line_wrap;
  logic [LADDR_W-1:0] line_mod;
  logic [WORD_W-1:0]  ram_rdata;
  logic [Q_W-1:0]     q_rdata;
  logic               q_room;

  // addresses past the array wrap around
  assign line_mod  = cmd_line_i % LADDR_W'(MEM_LINES);
  assign line_wrap = line_mod[LINE_W-1:0];

  assign cmd_ready_o = !st_busy && !rd_busy && q_room;
  assign wr_ready_o  = st_busy;
  assign cmd_fire    = cmd_valid_i && cmd_ready_o;
  assign wr_fire     = wr_valid_i && wr_ready_o;
  assign st_start    = cmd_fire && (cmd_kind_e'(cmd_write_i) == CMD_WRITE);
  assign rd_start    = cmd_fire && (cmd_kind_e'(cmd_write_i) == CMD_READ);

  lmr_line_seq #(
    .BEATS(BEATS), .LINE_W(LINE_W), .TAG_W(TAG_W), .SELF_STEP(1'b0)
  ) i_store_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(st_start),
    .line_i (line_wrap),
    .tag_i  (cmd_tag_i),
    .step_i (wr_fire),
    .busy_o (st_busy),
    .adv_o  (st_adv),
    .addr_o (st_addr),
    .tag_o  (st_tag_unused)
  );

  lmr_line_seq #(
    .BEATS(BEATS), .LINE_W(LINE_W), .TAG_W(TAG_W), .SELF_STEP(1'b1)
  ) i_read_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(rd_start),
    .line_i (line_wrap),
    .tag_i  (cmd_tag_i),
    .step_i (1'b0),
    .busy_o (rd_busy),
    .adv_o  (rd_push),
    .addr_o (rd_addr),
    .tag_o  (rd_tag)
  );

  // single port: the two sequencers never own the array together
  assign ram_addr = st_busy ? st_addr : rd_addr;

  lmr_word_ram #(.WORD_W(WORD_W), .WORDS(WORDS)) i_ram (
    .clk_i  (clk_i),
    .we_i   (st_adv),
    .addr_i (ram_addr),
    .wdata_i(wr_data_i),
    .rdata_o(ram_rdata)
  );

  assign rsp_fire = rsp_valid_o && rsp_ready_i;

  lmr_resp_fifo #(.W(Q_W), .DEPTH(Q_DEPTH), .NEED(BEATS)) i_rsp_q (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (rd_push),
    .wdata_i({rd_tag, ram_rdata}),
    .pop_i  (rsp_fire),
    .valid_o(rsp_valid_o),
    .rdata_o(q_rdata),
    .room_o (q_room)
  );

  assign rsp_tag_o  = q_rdata[Q_W-1 -: TAG_W];
  assign rsp_data_o = q_rdata[WORD_W-1:0];

  // R2
  no_dual_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_fire && wr_fire));

  // R2
  port_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(st_busy && rd_busy));

  // R6
  rsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=>
      (rsp_valid_o && $stable(rsp_tag_o) && $stable(rsp_data_o)));

  // R10
  read_starts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_start |=> (rd_busy && !cmd_ready_o));
endmodule

// File: tb/test_line_mem_responder.sv
module test_line_mem_responder;
  localparam int WORD_W = 64, LINE_BYTES = 64, MEM_LINES = 32, TAG_W = 4, LADDR_W = 26;
  localparam int BEATS = LINE_BYTES * 8 / WORD_W;
  localparam int WORDS = MEM_LINES * BEATS;
  localparam int MAXB  = 512;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cmd_valid = 1'b0, cmd_write = 1'b0, wr_valid = 1'b0, rsp_ready = 1'b0;
  logic [LADDR_W-1:0] cmd_line = '0;
  logic [TAG_W-1:0]   cmd_tag = '0;
  logic [WORD_W-1:0]  wr_data = '0;
  logic cmd_ready, wr_ready, rsp_valid;
  logic [TAG_W-1:0]  rsp_tag;
  logic [WORD_W-1:0] rsp_data;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [WORD_W-1:0] ref_mem [WORDS];
  logic [TAG_W-1:0]  exp_tag [MAXB];
  logic [WORD_W-1:0] exp_dat [MAXB];
  logic [TAG_W-1:0]  rx_tag  [MAXB];
  logic [WORD_W-1:0] rx_dat  [MAXB];
  int exp_n = 0, rx_n = 0, cmp_n = 0;

  always #2 clk = ~clk;

  line_mem_responder #(
    .WORD_W(WORD_W), .LINE_BYTES(LINE_BYTES), .MEM_LINES(MEM_LINES),
    .TAG_W(TAG_W), .LADDR_W(LADDR_W), .RESP_LINES(2)
  ) i_line_mem_responder (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_write_i(cmd_write),
    .cmd_line_i(cmd_line), .cmd_tag_i(cmd_tag),
    .wr_valid_i(wr_valid), .wr_ready_o(wr_ready), .wr_data_i(wr_data),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_tag_o(rsp_tag), .rsp_data_o(rsp_data)
  );

  // response monitor: values before the next rising edge decide a pop
  always @(negedge clk) begin
    if (rst_ni && rsp_valid && rsp_ready && rx_n < MAXB) begin
      rx_tag[rx_n] = rsp_tag;
      rx_dat[rx_n] = rsp_data;
      rx_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [WORD_W-1:0] pat(input int line, input int b, input int seed);
    return {32'(seed) ^ 32'hC3A5_0000, 16'(line), 16'(b * 257 + seed)};
  endfunction

  task automatic set_ready(input logic v);
    @(posedge clk); #1 rsp_ready = v;
  endtask

  task automatic send_cmd(input logic wr, input int line, input int tag);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_line = LADDR_W'(line); cmd_tag = TAG_W'(tag);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic write_line(input int line, input int seed);
    send_cmd(1'b1, line, 0);
    chk(wr_ready && !cmd_ready, "R2", "ready pair during store",
        {62'd0, cmd_ready, wr_ready}, 64'd1);
    for (int b = 0; b < BEATS; b++) begin
      wr_valid = 1'b1; wr_data = pat(line, b, seed);
      while (!wr_ready) @(negedge clk);
      ref_mem[(line % MEM_LINES) * BEATS + b] = wr_data;
      @(negedge clk);
    end
    wr_valid = 1'b0;
    chk(!wr_ready && cmd_ready, "R3", "ready pair after last beat",
        {62'd0, cmd_ready, wr_ready}, 64'd2);
  endtask

  task automatic read_line(input int line, input int tag);
    send_cmd(1'b0, line, tag);
    chk(!cmd_ready, "R10", "cmd ready while burst queues", {63'd0, cmd_ready}, 64'd0);
    for (int b = 0; b < BEATS; b++) begin
      exp_tag[exp_n] = TAG_W'(tag);
      exp_dat[exp_n] = ref_mem[(line % MEM_LINES) * BEATS + b];
      exp_n++;
    end
  endtask

  task automatic drain_and_compare(input string req);
    int guard = 0;
    while (rx_n < exp_n && guard < 400) begin @(negedge clk); guard++; end
    repeat (3) @(negedge clk);
    chk(rx_n == exp_n, req, "beat count", 64'(rx_n), 64'(exp_n));
    for (int i = cmp_n; i < exp_n && i < rx_n; i++) begin
      chk(rx_tag[i] == exp_tag[i], req, "beat tag", 64'(rx_tag[i]), 64'(exp_tag[i]));
      chk(rx_dat[i] == exp_dat[i], req, "beat data", rx_dat[i], exp_dat[i]);
    end
    cmp_n = exp_n;
    rx_n = exp_n;
    chk(!rsp_valid, "R8", "valid after drain", {63'd0, rsp_valid}, 64'd0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(cmd_ready && !wr_ready && !rsp_valid, "R1", "reset outputs",
        {61'd0, rsp_valid, wr_ready, cmd_ready}, 64'd1);
  endtask

  task automatic t_write_read;
    set_ready(1'b1);
    write_line(3, 1);
    write_line(4, 2);
    read_line(3, 5);
    read_line(4, 9);
    drain_and_compare("R4");
  endtask

  task automatic t_wrap;
    write_line(MEM_LINES + 7, 3);
    read_line(7, 2);
    read_line(2 * MEM_LINES + 7, 11);
    drain_and_compare("R5");
  endtask

  task automatic t_stray_data;
    // write-data while idle must not reach the array (R2)
    @(negedge clk);
    wr_valid = 1'b1; wr_data = 64'hDEAD_BEEF_0000_0001;
    repeat (4) begin
      @(negedge clk);
      chk(!wr_ready, "R2", "data ready while idle", {63'd0, wr_ready}, 64'd0);
    end
    wr_valid = 1'b0;
    read_line(3, 1);
    drain_and_compare("R2");
  endtask

  task automatic t_backpressure;
    logic [TAG_W-1:0] t0; logic [WORD_W-1:0] d0;
    set_ready(1'b0);
    read_line(4, 6);
    read_line(3, 7);
    repeat (BEATS + 4) @(negedge clk);
    chk(!cmd_ready, "R7", "cmd ready with queue full", {63'd0, cmd_ready}, 64'd0);
    chk(rsp_valid, "R6", "valid held under backpressure", {63'd0, rsp_valid}, 64'd1);
    t0 = rsp_tag; d0 = rsp_data;
    repeat (5) @(negedge clk);
    chk(rsp_tag == t0 && rsp_data == d0, "R6", "head beat stable", rsp_data, d0);
    chk(rx_n == cmp_n, "R6", "beats taken while ready low", 64'(rx_n), 64'(cmp_n));
    set_ready(1'b1);
    read_line(7, 12);
    drain_and_compare("R7");
  endtask

  task automatic t_reset_keeps;
    @(negedge clk); rst_ni = 1'b0;
    repeat (2) @(negedge clk); rst_ni = 1'b1;
    t_reset();
    read_line(4, 3);
    read_line(7, 4);
    drain_and_compare("R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_write_read();
    t_wrap();
    t_stray_data();
    t_backpressure();
    t_reset_keeps();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule